// File: doc/BRIEF.md
# Page Table Entry Status Updater

This block sits between a small translation cache and a shared memory bus. It keeps the status bits of page table entries up to date. A CPU-side request names a virtual page number and says whether the access is a load or a store. On a miss the block reads the entry from memory and checks its valid bit. A clear valid bit gives a page-fault response and nothing else happens. A valid entry has its accessed bit merged in, and a store also merges in the dirty bit. The merged word is written back only when it differs from what was read.

Translations are cached, and each cached entry remembers whether the page is already dirty. A load that hits the cache completes with no bus traffic. A store that hits also completes with no bus traffic, provided the cached copy is dirty. A store that hits a clean copy sets the dirty bit lazily. The block re-reads the entry, ORs in the status bits and writes the word back. The cached copy is then marked dirty, so the next store to that page skips the memory update.

Every read-merge-write holds a bus lock from the read request until the write is acknowledged. A second bus master, which stands for the software that clears status bits, can still issue writes. Such a write is held off while the lock is up and is completed afterwards.

Top module: `pte_status_unit`

## Requirements
- R1: An entry word has the valid flag in bit 0, the accessed flag in bit 5, the dirty flag in bit 6 and the frame number in bits 31:12, and it is fetched from address PT_BASE + 4*vpn. When a fetched entry has bit 0 clear, the response carries cpu_fault_o=1. No memory write is made, and the translation is not cached, so the next access to that page fetches again.
- R2: A load or store that misses the cache, on a valid entry whose bit 5 is 0, leaves bit 5 of the entry in memory set to 1. The response returns the frame number from bits 31:12 with cpu_fault_o=0.
- R3: A store that misses on a valid entry with bits 5 and 6 both clear sets both bits with a single memory write.
- R4: A load never changes bit 6. The block never clears any entry bit.
- R5: No memory write is issued when the status bits the access needs are already set in the fetched word: bit 5 for a load, bits 5 and 6 for a store.
- R6: Every write the block makes keeps all bits other than 5 and 6 exactly as they were read.
- R7: A load that hits the cache, or a store that hits a cached copy already marked dirty, completes without any bus request. cpu_ready_o is a one-cycle pulse.
- R8: A store that hits a clean cached copy re-reads the entry, ORs in bits 5 and 6 and writes the word back. The cached copy becomes dirty, so a further store to that page makes no bus request.
- R9: If that re-read finds bits 5 and 6 already set, no write is made, and the cached copy is still marked dirty.
- R10: mem_lock_o is held from the read request of a read-merge-write until its write acknowledge. A second-master write that arrives while the lock is held is completed after the lock drops, and it is not lost.
- R11: The cache is direct mapped on the low vpn bits. A page that maps to an occupied slot evicts the old page, and a later access to the evicted page fetches its entry again.
- R12: After reset, cpu_ready_o, mem_req_o and mem_lock_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 for a store, 0 for a load |
| cpu_vpn_i | input | VPN_W | Virtual page number |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_fault_o | output | 1 | Page fault, valid with cpu_ready_o |
| cpu_pfn_o | output | 20 | Frame number, valid with cpu_ready_o |
| ext_req_i | input | 1 | Second-master write request, held until ext_ack_o |
| ext_addr_i | input | ADDR_W | Second-master write address |
| ext_wdata_i | input | 32 | Second-master write data |
| ext_ack_o | output | 1 | Second-master write done |
| mem_req_o | output | 1 | Bus request, held until mem_ack_i |
| mem_we_o | output | 1 | Bus write enable |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_rdata_i | input | 32 | Bus read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Bus acknowledge, one-cycle pulse |
| mem_lock_o | output | 1 | Bus lock for read-merge-write |

## Verification
The bench builds the block with VPN_W=6, ENTRIES=2 and PT_BASE=0x4000. The whole page table then fits a 64-word memory model, and the second master can preload it. With only two cache slots, pages 9 and 11 collide, so eviction and re-fetch can be reached in a few accesses. A clean page can also be kept cached while other pages come and go, and this is what sets up the lazy dirty update. The lock scenario starts a second-master write on the same entry during a dirty update. It then checks the order of the two writes in the memory log.

// File: rtl/pte_status_pkg.sv
package pte_status_pkg;
  localparam int PTE_W   = 32;
  localparam int V_BIT   = 0;
  localparam int A_BIT   = 5;
  localparam int D_BIT   = 6;
  localparam int PFN_LSB = 12;
  localparam int PFN_W   = PTE_W - PFN_LSB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WALK_RD, ST_WALK_WR, ST_DIRT_RD, ST_DIRT_WR, ST_RESP
  } rmw_state_e;

  typedef enum logic [1:0] {
    OWN_NONE, OWN_INT, OWN_EXT
  } bus_owner_e;
endpackage

// File: rtl/pte_tlb.sv
module pte_tlb #(
  parameter int VPN_W   = 20,
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic             dirty_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_dirty_i,
  input  logic             mark_i,
  input  logic [VPN_W-1:0] mark_vpn_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [ENTRIES-1:0]            ent_vld, ent_dty;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;

  logic [IDX_W-1:0] look_idx, fill_idx, mark_idx;
  assign look_idx = look_vpn_i[IDX_W-1:0];
  assign fill_idx = fill_vpn_i[IDX_W-1:0];
  assign mark_idx = mark_vpn_i[IDX_W-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             vld_q, dty_q;
    logic [TAG_W-1:0] tag_q;
    logic [PFN_W-1:0] pfn_q;
    logic             sel_fill, sel_mark;

    assign sel_fill = fill_i && (fill_idx == IDX_W'(g));
    assign sel_mark = mark_i && (mark_idx == IDX_W'(g)) && vld_q &&
                      (tag_q == mark_vpn_i[VPN_W-1:IDX_W]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dty_q <= 1'b0;
        tag_q <= '0;
        pfn_q <= '0;
      end else if (sel_fill) begin
        vld_q <= 1'b1;
        dty_q <= fill_dirty_i;
        tag_q <= fill_vpn_i[VPN_W-1:IDX_W];
        pfn_q <= fill_pfn_i;
      end else if (sel_mark) begin
        dty_q <= 1'b1;
      end
    end

    assign ent_vld[g] = vld_q;
    assign ent_dty[g] = dty_q;
    assign ent_tag[g] = tag_q;
    assign ent_pfn[g] = pfn_q;
  end

  assign hit_o   = ent_vld[look_idx] && (ent_tag[look_idx] == look_vpn_i[VPN_W-1:IDX_W]);
  assign pfn_o   = ent_pfn[look_idx];
  assign dirty_o = ent_dty[look_idx];
endmodule

// File: rtl/pte_bus_arb.sv
module pte_bus_arb
  import pte_status_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_req_i,
  input  logic              int_we_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic [PTE_W-1:0]  int_wdata_i,
  input  logic              int_lock_i,
  output logic              int_ack_o,
  input  logic              ext_req_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [PTE_W-1:0]  ext_wdata_i,
  output logic              ext_ack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PTE_W-1:0]  mem_wdata_o,
  output logic              mem_lock_o,
  input  logic              mem_ack_i
);
  bus_owner_e owner_q, owner_d;

  // internal side keeps the bus for as long as it holds the lock
  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: if (int_req_i) owner_d = OWN_INT;
                else if (ext_req_i) owner_d = OWN_EXT;
      OWN_INT:  if (!int_req_i && !int_lock_i) owner_d = OWN_NONE;
      OWN_EXT:  if (mem_ack_i) owner_d = OWN_NONE;
      default:  owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  logic is_int, is_ext;
  assign is_int = (owner_q == OWN_INT);
  assign is_ext = (owner_q == OWN_EXT);

  assign mem_req_o   = (is_int && int_req_i) || (is_ext && ext_req_i);
  assign mem_we_o    = is_int ? int_we_i : is_ext;
  assign mem_addr_o  = is_int ? int_addr_i : ext_addr_i;
  assign mem_wdata_o = is_int ? int_wdata_i : ext_wdata_i;
  assign mem_lock_o  = is_int && int_lock_i;
  assign int_ack_o   = is_int && mem_ack_i;
  assign ext_ack_o   = is_ext && mem_ack_i;
endmodule

// File: rtl/pte_rmw_ctrl.sv
module pte_rmw_ctrl
  import pte_status_pkg::*;
#(
  parameter int                VPN_W   = 20,
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] PT_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [VPN_W-1:0]  cpu_vpn_i,
  output logic              cpu_ready_o,
  output logic              cpu_fault_o,
  output logic [PFN_W-1:0]  cpu_pfn_o,
  output logic [VPN_W-1:0]  tlb_vpn_o,
  input  logic              tlb_hit_i,
  input  logic [PFN_W-1:0]  tlb_pfn_i,
  input  logic              tlb_dirty_i,
  output logic              fill_o,
  output logic [VPN_W-1:0]  fill_vpn_o,
  output logic [PFN_W-1:0]  fill_pfn_o,
  output logic              fill_dirty_o,
  output logic              mark_o,
  output logic [VPN_W-1:0]  mark_vpn_o,
  output logic              int_req_o,
  output logic              int_we_o,
  output logic [ADDR_W-1:0] int_addr_o,
  output logic [PTE_W-1:0]  int_wdata_o,
  output logic              int_lock_o,
  input  logic              int_ack_i,
  input  logic [PTE_W-1:0]  int_rdata_i
);
  rmw_state_e         state_q, state_d;
  logic [VPN_W-1:0]   vpn_q, vpn_d;
  logic               we_q, we_d;
  logic [PFN_W-1:0]   pfn_q, pfn_d;
  logic               fault_q, fault_d;
  logic [PTE_W-1:0]   wr_q, wr_d;

  logic [PTE_W-1:0] need_mask, merged;
  logic             must_write;

  assign need_mask  = (PTE_W'(1) << A_BIT) | (we_q ? (PTE_W'(1) << D_BIT) : '0);
  assign merged     = int_rdata_i | need_mask;
  assign must_write = (merged != int_rdata_i);

  always_comb begin
    state_d = state_q;
    vpn_d   = vpn_q;
    we_d    = we_q;
    pfn_d   = pfn_q;
    fault_d = fault_q;
    wr_d    = wr_q;
    fill_o       = 1'b0;
    fill_dirty_o = 1'b0;
    mark_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cpu_req_i) begin
        vpn_d   = cpu_vpn_i;
        we_d    = cpu_we_i;
        fault_d = 1'b0;
        if (tlb_hit_i) begin
          pfn_d   = tlb_pfn_i;
          state_d = (cpu_we_i && !tlb_dirty_i) ? ST_DIRT_RD : ST_RESP;
        end else begin
          state_d = ST_WALK_RD;
        end
      end
      ST_WALK_RD: if (int_ack_i) begin
        pfn_d = int_rdata_i[PTE_W-1:PFN_LSB];
        if (!int_rdata_i[V_BIT]) begin
          fault_d = 1'b1;
          state_d = ST_RESP;
        end else if (must_write) begin
          wr_d    = merged;
          state_d = ST_WALK_WR;
        end else begin
          fill_o       = 1'b1;
          fill_dirty_o = int_rdata_i[D_BIT];
          state_d      = ST_RESP;
        end
      end
      ST_WALK_WR: if (int_ack_i) begin
        fill_o       = 1'b1;
        fill_dirty_o = wr_q[D_BIT];
        state_d      = ST_RESP;
      end
      ST_DIRT_RD: if (int_ack_i) begin
        if (must_write) begin
          wr_d    = merged;
          state_d = ST_DIRT_WR;
        end else begin
          mark_o  = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_DIRT_WR: if (int_ack_i) begin
        mark_o  = 1'b1;
        state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      we_q    <= 1'b0;
      pfn_q   <= '0;
      fault_q <= 1'b0;
      wr_q    <= '0;
    end else begin
      state_q <= state_d;
      vpn_q   <= vpn_d;
      we_q    <= we_d;
      pfn_q   <= pfn_d;
      fault_q <= fault_d;
      wr_q    <= wr_d;
    end
  end

  logic in_rd, in_wr;
  assign in_rd = (state_q == ST_WALK_RD) || (state_q == ST_DIRT_RD);
  assign in_wr = (state_q == ST_WALK_WR) || (state_q == ST_DIRT_WR);

  assign int_req_o   = in_rd || in_wr;
  assign int_we_o    = in_wr;
  assign int_lock_o  = in_rd || in_wr;
  assign int_addr_o  = PT_BASE + ADDR_W'({vpn_q, 2'b00});
  assign int_wdata_o = wr_q;

  assign tlb_vpn_o    = cpu_vpn_i;
  assign fill_vpn_o   = vpn_q;
  assign fill_pfn_o   = (state_q == ST_WALK_RD) ? int_rdata_i[PTE_W-1:PFN_LSB] : pfn_q;
  assign mark_vpn_o   = vpn_q;

  assign cpu_ready_o = (state_q == ST_RESP);
  assign cpu_fault_o = fault_q;
  assign cpu_pfn_o   = pfn_q;
endmodule

// File: rtl/pte_status_unit.sv
module pte_status_unit
  import pte_status_pkg::*;
#(
  parameter int                VPN_W   = 20,
  parameter int                ENTRIES = 16,
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] PT_BASE = 32'h0010_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [VPN_W-1:0]  cpu_vpn_i,
  output logic              cpu_ready_o,
  output logic              cpu_fault_o,
  output logic [19:0]       cpu_pfn_o,
  input  logic              ext_req_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [31:0]       ext_wdata_i,
  output logic              ext_ack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              mem_lock_o
);
  logic [VPN_W-1:0] tlb_vpn, fill_vpn, mark_vpn;
  logic             tlb_hit, tlb_dirty, fill, fill_dirty, mark;
  logic [PFN_W-1:0] tlb_pfn, fill_pfn;

  logic              int_req, int_we, int_lock, int_ack;
  logic [ADDR_W-1:0] int_addr;
  logic [PTE_W-1:0]  int_wdata;

  pte_tlb #(.VPN_W(VPN_W), .ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_tlb (
    .clk_i, .rst_ni,
    .look_vpn_i  (tlb_vpn),
    .hit_o       (tlb_hit),
    .pfn_o       (tlb_pfn),
    .dirty_o     (tlb_dirty),
    .fill_i      (fill),
    .fill_vpn_i  (fill_vpn),
    .fill_pfn_i  (fill_pfn),
    .fill_dirty_i(fill_dirty),
    .mark_i      (mark),
    .mark_vpn_i  (mark_vpn)
  );

  pte_rmw_ctrl #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .PT_BASE(PT_BASE)) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_vpn_i,
    .cpu_ready_o, .cpu_fault_o, .cpu_pfn_o,
    .tlb_vpn_o   (tlb_vpn),
    .tlb_hit_i   (tlb_hit),
    .tlb_pfn_i   (tlb_pfn),
    .tlb_dirty_i (tlb_dirty),
    .fill_o      (fill),
    .fill_vpn_o  (fill_vpn),
    .fill_pfn_o  (fill_pfn),
    .fill_dirty_o(fill_dirty),
    .mark_o      (mark),
    .mark_vpn_o  (mark_vpn),
    .int_req_o   (int_req),
    .int_we_o    (int_we),
    .int_addr_o  (int_addr),
    .int_wdata_o (int_wdata),
    .int_lock_o  (int_lock),
    .int_ack_i   (int_ack),
    .int_rdata_i (mem_rdata_i)
  );

  pte_bus_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i, .rst_ni,
    .int_req_i  (int_req),
    .int_we_i   (int_we),
    .int_addr_i (int_addr),
    .int_wdata_i(int_wdata),
    .int_lock_i (int_lock),
    .int_ack_o  (int_ack),
    .ext_req_i, .ext_addr_i, .ext_wdata_i, .ext_ack_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_lock_o,
    .mem_ack_i
  );
endmodule

// File: rtl/pte_status_unit_chk.sv
module pte_status_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_wdata_o,
  input logic [31:0] mem_rdata_i,
  input logic        mem_ack_i,
  input logic        mem_lock_o,
  input logic        ext_ack_o,
  input logic        cpu_ready_o,
  input logic        cpu_fault_o
);
  localparam logic [31:0] STAT_MASK = 32'h0000_0060;

  logic [31:0] rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  rd_q <= '0;
    else if (mem_ack_i && !mem_we_o && mem_lock_o) rd_q <= mem_rdata_i;
  end

  p_fault_invalid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && cpu_fault_o |-> !rd_q[0]);

  p_sets_accessed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_lock_o |-> mem_wdata_o[5]);

  p_never_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_lock_o |-> ((mem_wdata_o & rd_q) == rd_q));

  p_write_needed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_lock_o |-> (mem_wdata_o != rd_q));

  p_keep_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_lock_o |->
      ((mem_wdata_o & ~STAT_MASK) == (rd_q & ~STAT_MASK)));

  p_ready_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);

  p_ext_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o |-> !ext_ack_o);

  p_lock_until_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> $past(mem_ack_i));
endmodule

bind pte_status_unit pte_status_unit_chk u_chk (
  .clk_i, .rst_ni, .mem_req_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i,
  .mem_ack_i, .mem_lock_o, .ext_ack_o, .cpu_ready_o, .cpu_fault_o
);

// File: tb/pte_status_unit_tb.sv
module pte_status_unit_tb;
  localparam int          VPN_W   = 6;
  localparam int          ENTRIES = 2;
  localparam int          ADDR_W  = 32;
  localparam logic [31:0] PT_BASE = 32'h0000_4000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic              cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [VPN_W-1:0]  cpu_vpn_i = '0;
  logic              cpu_ready_o, cpu_fault_o;
  logic [19:0]       cpu_pfn_o;
  logic              ext_req_i = 1'b0;
  logic [ADDR_W-1:0] ext_addr_i = '0;
  logic [31:0]       ext_wdata_i = '0;
  logic              ext_ack_o;
  logic              mem_req_o, mem_we_o, mem_lock_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0]       mem_wdata_o;
  logic [31:0]       mem_rdata_i;
  logic              mem_ack_i;

  pte_status_unit #(.VPN_W(VPN_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PT_BASE(PT_BASE)) u_dut (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_we_i, .cpu_vpn_i, .cpu_ready_o, .cpu_fault_o,
    .cpu_pfn_o, .ext_req_i, .ext_addr_i, .ext_wdata_i, .ext_ack_o, .mem_req_o,
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i, .mem_lock_o
  );

  // memory model: one-cycle acknowledge, write log
  logic [31:0] pt_mem [64];
  int          rd_cnt, wr_cnt;
  logic [31:0] log_last, log_prev;
  logic [31:0] off;
  assign off = mem_addr_o - PT_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack_i   <= 1'b0;
      mem_rdata_i <= '0;
      rd_cnt      <= 0;
      wr_cnt      <= 0;
      log_last    <= '0;
      log_prev    <= '0;
      for (int i = 0; i < 64; i++) pt_mem[i] <= '0;
    end else begin
      mem_ack_i <= mem_req_o && !mem_ack_i;
      if (mem_req_o && !mem_ack_i) begin
        if (mem_we_o) begin
          pt_mem[off[7:2]] <= mem_wdata_o;
          wr_cnt   <= wr_cnt + 1;
          log_prev <= log_last;
          log_last <= mem_wdata_o;
        end else begin
          mem_rdata_i <= pt_mem[off[7:2]];
          rd_cnt      <= rd_cnt + 1;
        end
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic cpu_access(input int vpn, input bit we, output bit flt, output logic [19:0] pfn);
    @(negedge clk_i);
    cpu_req_i = 1'b1;
    cpu_we_i  = we;
    cpu_vpn_i = VPN_W'(vpn);
    do @(negedge clk_i); while (!cpu_ready_o);
    flt = cpu_fault_o;
    pfn = cpu_pfn_o;
    cpu_req_i = 1'b0;
  endtask

  task automatic ext_write(input int vpn, input logic [31:0] data);
    @(negedge clk_i);
    ext_req_i   = 1'b1;
    ext_addr_i  = PT_BASE + 32'(vpn * 4);
    ext_wdata_i = data;
    do @(negedge clk_i); while (!ext_ack_o);
    ext_req_i = 1'b0;
  endtask

  bit          f;
  logic [19:0] p;
  int          r0, w0;

  task automatic t_reset;
    check_eq("R12 ready", 32'(cpu_ready_o), 0);
    check_eq("R12 req", 32'(mem_req_o), 0);
    check_eq("R12 lock", 32'(mem_lock_o), 0);
  endtask

  task automatic t_fault;
    ext_write(2, 32'h12345E9E);
    w0 = wr_cnt;
    cpu_access(2, 0, f, p);
    check_eq("R1 fault", 32'(f), 1);
    check_eq("R1 no write", 32'(wr_cnt - w0), 0);
    check_eq("R1 mem", pt_mem[2], 32'h12345E9E);
    r0 = rd_cnt;
    cpu_access(2, 1, f, p);
    check_eq("R1 refetch", 32'(rd_cnt - r0), 1);
    check_eq("R1 fault store", 32'(f), 1);
  endtask

  task automatic t_walk_and_lazy;
    ext_write(4, 32'hABCDEE9F);
    w0 = wr_cnt;
    cpu_access(4, 0, f, p);
    check_eq("R2 fault", 32'(f), 0);
    check_eq("R2 pfn", 32'(p), 32'hABCDE);
    check_eq("R2 R4 R6 mem", pt_mem[4], 32'hABCDEEBF);
    check_eq("R2 one write", 32'(wr_cnt - w0), 1);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(4, 0, f, p);
    check_eq("R7 load hit traffic", 32'(rd_cnt - r0 + wr_cnt - w0), 0);
    check_eq("R7 pfn", 32'(p), 32'hABCDE);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(4, 1, f, p);
    check_eq("R8 reread", 32'(rd_cnt - r0), 1);
    check_eq("R8 write", 32'(wr_cnt - w0), 1);
    check_eq("R8 R6 mem", pt_mem[4], 32'hABCDEEFF);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(4, 1, f, p);
    check_eq("R8 R7 dirty hit traffic", 32'(rd_cnt - r0 + wr_cnt - w0), 0);
  endtask

  task automatic t_store_miss;
    ext_write(9, 32'h00777001);
    w0 = wr_cnt;
    cpu_access(9, 1, f, p);
    check_eq("R3 single write", 32'(wr_cnt - w0), 1);
    check_eq("R3 mem", pt_mem[9], 32'h00777061);
    check_eq("R3 pfn", 32'(p), 32'h00777);
  endtask

  task automatic t_skip;
    ext_write(11, 32'h0BEEF021);
    ext_write(8, 32'h0CAFE061);
    w0 = wr_cnt;
    cpu_access(11, 0, f, p);
    check_eq("R5 load A set", 32'(wr_cnt - w0), 0);
    check_eq("R5 pfn", 32'(p), 32'h0BEEF);
    w0 = wr_cnt;
    cpu_access(8, 1, f, p);
    check_eq("R5 store A D set", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_dirty_found;
    ext_write(11, 32'h0BEEF061);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(11, 1, f, p);
    check_eq("R9 reread", 32'(rd_cnt - r0), 1);
    check_eq("R9 no write", 32'(wr_cnt - w0), 0);
    r0 = rd_cnt;
    cpu_access(11, 1, f, p);
    check_eq("R9 marked dirty", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_conflict;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(9, 0, f, p);
    check_eq("R11 refetch 9", 32'(rd_cnt - r0), 1);
    check_eq("R11 no write", 32'(wr_cnt - w0), 0);
    check_eq("R11 pfn", 32'(p), 32'h00777);
    r0 = rd_cnt;
    cpu_access(11, 0, f, p);
    check_eq("R11 refetch 11", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_lock;
    bit          f2;
    logic [19:0] p2;
    ext_write(20, 32'h05555801);
    cpu_access(20, 0, f, p);
    check_eq("R2 mem 20", pt_mem[20], 32'h05555821);
    fork
      cpu_access(20, 1, f2, p2);
      begin
        do @(negedge clk_i); while (!mem_lock_o);
        ext_write(20, 32'h05555001);
      end
    join
    check_eq("R10 rmw first", log_prev, 32'h05555861);
    check_eq("R10 ext last", log_last, 32'h05555001);
    check_eq("R10 not lost", pt_mem[20], 32'h05555001);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fault();
    t_walk_and_lazy();
    t_store_miss();
    t_skip();
    t_dirty_found();
    t_conflict();
    t_lock();
    repeat (4) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule